// File: doc/BRIEF.md
# SMBus Charger Register Interface

This block is the host-facing control port of a battery charger. It is an SMBus slave that answers the Write-Word and Read-Word protocols for a small set of charger setting registers. The clock and data pins are oversampled by the system clock. The block detects START and STOP conditions and compares the address byte with its own address. It then takes a command byte and either a two-byte data word to write, or a repeated START followed by a word to read. It never starts bus traffic of its own.

Four writable registers hold the charger setting words: the options word, the charge-current limit, the charge-voltage limit and the input-current limit. Each current or voltage word has a numeric field, and the bits outside that field always read as zero. A write whose field value lies outside the legal window does not hold that value. The register is cleared instead, and a terminate flag is raised for the charging logic. Two read-only identification codes return constants. Every accepted word write gives a one-cycle strobe with the index of the register that was written, so that downstream logic can pick up the new setting.

Top module: `chg_smbus_regs`

## Requirements
- R1: The block acknowledges only the 7-bit address 0x09 (0x12 with the R/W bit at zero). For any other address it drives no acknowledge and changes no register.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits are sampled on the rising edge of SCL, most significant bit first. The 9th clock of each byte is the acknowledge. Data words go low byte first, then high byte, in both directions. A master NACK after the low byte of a read ends the transfer, and the block then drives nothing on the following clock.
- R3: After reset, the command codes read: 0x12 gives 0x7904, 0x14 gives 0x0000, 0x15 gives 0x0000 and 0x3F gives 0x1000.
- R4: Command 0x14 (charge current) keeps only bits 12:6. If that field is below 2, the register is cleared and terminate is raised.
- R5: Command 0x15 (charge voltage) keeps only bits 14:4. If that field is below 64 or above 1200, the register is cleared and terminate is raised.
- R6: Command 0x3F (input current) keeps only bits 12:7. If that field is zero, the register is cleared and terminate is raised.
- R7: Command 0x12 (options) stores all 16 bits exactly as written.
- R8: Reads of 0xFE return 0x0040 and reads of 0xFF return 0x000A. Writes to these two codes, or to any unlisted code, are acknowledged and change nothing. Reads of an unlisted code return 0xFFFF.
- R9: When the high data byte of a write to one of the four writable registers is accepted, wr_stb pulses for exactly one cycle. wr_idx then gives the register: 0 = options, 1 = charge current, 2 = charge voltage, 3 = input current. Ignored writes give no strobe.
- R10: term_o rises on a rejected write. It falls on a legal write to any of the three current and voltage registers. A write to the options register leaves it unchanged.
- R11: sda_oe is never asserted while the bus is idle, that is, after reset or after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level |
| sda_oe | output | 1 | When high, the data pin is pulled low |
| opt_q | output | 16 | Options register |
| ichg_q | output | 16 | Charge-current register |
| vchg_q | output | 16 | Charge-voltage register |
| iin_q | output | 16 | Input-current register |
| wr_stb | output | 1 | One-cycle pulse on an accepted register write |
| wr_idx | output | 2 | Index of the register that was written |
| term_o | output | 1 | Charge-terminate flag |

## Verification
The bench builds the block with its default parameters: a two-stage pin synchronizer, address 0x09, and field limits of 2, 64 to 1200, and 1. With these values each range edge (field values 1/2, 63/64, 1200/1201, and 0) can be reached with a single write word. A bus half-period of 16 system clocks leaves the synchronizer latency well inside each SCL phase, so the cycle in which the acknowledge and the read data bits appear is fixed. The reference model holds the expected register and flag values as integers and compares them with the outputs on every clock outside a transfer. It also checks the acknowledges, the strobe count and the strobe index for each transaction.

// File: rtl/chg_smbus_pkg.sv
package chg_smbus_pkg;
  localparam logic [7:0]  CMD_OPT  = 8'h12;
  localparam logic [7:0]  CMD_ICHG = 8'h14;
  localparam logic [7:0]  CMD_VCHG = 8'h15;
  localparam logic [7:0]  CMD_IIN  = 8'h3F;
  localparam logic [7:0]  CMD_MFG  = 8'hFE;
  localparam logic [7:0]  CMD_DEV  = 8'hFF;
  localparam logic [15:0] OPT_POR  = 16'h7904;
  localparam logic [15:0] IIN_POR  = 16'h1000;
  localparam logic [15:0] MFG_CODE = 16'h0040;
  localparam logic [15:0] DEV_CODE = 16'h000A;
  localparam logic [15:0] NO_REG   = 16'hFFFF;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_WLO, PH_WHI, PH_RLO, PH_RHI, PH_DONE
  } phase_t;

  typedef enum logic [1:0] {RI_OPT, RI_ICHG, RI_VCHG, RI_IIN} reg_idx_t;
endpackage

// File: rtl/smb_pin_sync.sv
module smb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
  import chg_smbus_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h09
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_ev,
  input  logic        stop_ev,
  input  logic [15:0] rd_word,
  output logic [7:0]  cmd_q,
  output logic [15:0] wdata_q,
  output logic        wr_en,
  output logic        sda_oe
);
  phase_t     ph;
  logic [3:0] bitcnt;
  logic [7:0] rx, tx, lo_q;
  logic       rw, mack, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; bitcnt <= '0; rx <= '0; tx <= '0; lo_q <= '0;
      rw <= 1'b0; mack <= 1'b0; oe_q <= 1'b0; cmd_q <= '0;
      wdata_q <= '0; wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        ph <= PH_ADDR; bitcnt <= '0; oe_q <= 1'b0;
      end else if (stop_ev) begin
        ph <= PH_IDLE; bitcnt <= '0; oe_q <= 1'b0;
      end else if (ph != PH_IDLE && ph != PH_DONE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) rx <= {rx[6:0], sda_s};
          else mack <= ~sda_s;
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (ph)
              PH_ADDR: if (rx[7:1] == ADDR7) begin
                         oe_q <= 1'b1; rw <= rx[0];
                       end else ph <= PH_DONE;
              PH_CMD:  begin cmd_q <= rx; oe_q <= 1'b1; end
              PH_WLO:  begin lo_q <= rx; oe_q <= 1'b1; end
              PH_WHI:  begin wdata_q <= {rx, lo_q}; wr_en <= 1'b1; oe_q <= 1'b1; end
              default: oe_q <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            oe_q   <= 1'b0;
            case (ph)
              PH_ADDR: if (rw) begin
                         ph <= PH_RLO; tx <= rd_word[7:0]; oe_q <= ~rd_word[7];
                       end else ph <= PH_CMD;
              PH_CMD:  ph <= PH_WLO;
              PH_WLO:  ph <= PH_WHI;
              PH_RLO:  if (mack) begin
                         ph <= PH_RHI; tx <= rd_word[15:8]; oe_q <= ~rd_word[15];
                       end else ph <= PH_DONE;
              default: ph <= PH_DONE;
            endcase
          end else if (bitcnt != 4'd0 && (ph == PH_RLO || ph == PH_RHI)) begin
            tx   <= {tx[6:0], 1'b0};
            oe_q <= ~tx[6];
          end
        end
      end
    end
  end

  assign sda_oe = oe_q;

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE) |-> !oe_q);
  // R9
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

// File: rtl/chg_reg_bank.sv
module chg_reg_bank
  import chg_smbus_pkg::*;
#(
  parameter int ICHG_LSB = 6,
  parameter int ICHG_MSB = 12,
  parameter int ICHG_MIN = 2,
  parameter int VCHG_LSB = 4,
  parameter int VCHG_MSB = 14,
  parameter int VCHG_MIN = 64,
  parameter int VCHG_MAX = 1200,
  parameter int IIN_LSB  = 7,
  parameter int IIN_MSB  = 12,
  parameter int IIN_MIN  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  cmd,
  input  logic [15:0] wdata,
  output logic [15:0] opt_q,
  output logic [15:0] ichg_q,
  output logic [15:0] vchg_q,
  output logic [15:0] iin_q,
  output logic [15:0] rd_word,
  output logic        wr_stb,
  output logic [1:0]  wr_idx,
  output logic        term_o
);
  localparam logic [15:0] ICHG_MASK = 16'((32'd1 << (ICHG_MSB + 1)) - (32'd1 << ICHG_LSB));
  localparam logic [15:0] VCHG_MASK = 16'((32'd1 << (VCHG_MSB + 1)) - (32'd1 << VCHG_LSB));
  localparam logic [15:0] IIN_MASK  = 16'((32'd1 << (IIN_MSB + 1)) - (32'd1 << IIN_LSB));

  logic [15:0] ichg_fld, vchg_fld, iin_fld;
  logic        ichg_ok, vchg_ok, iin_ok;

  always_comb begin
    ichg_fld = (wdata & ICHG_MASK) >> ICHG_LSB;
    vchg_fld = (wdata & VCHG_MASK) >> VCHG_LSB;
    iin_fld  = (wdata & IIN_MASK) >> IIN_LSB;
    ichg_ok  = ichg_fld >= 16'(ICHG_MIN);
    vchg_ok  = (vchg_fld >= 16'(VCHG_MIN)) && (vchg_fld <= 16'(VCHG_MAX));
    iin_ok   = iin_fld >= 16'(IIN_MIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q <= OPT_POR; ichg_q <= '0; vchg_q <= '0; iin_q <= IIN_POR;
      wr_stb <= 1'b0; wr_idx <= RI_OPT; term_o <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (wr_en) begin
        case (cmd)
          CMD_OPT: begin
            opt_q <= wdata; wr_stb <= 1'b1; wr_idx <= RI_OPT;
          end
          CMD_ICHG: begin
            ichg_q <= ichg_ok ? (wdata & ICHG_MASK) : '0;
            term_o <= ~ichg_ok; wr_stb <= 1'b1; wr_idx <= RI_ICHG;
          end
          CMD_VCHG: begin
            vchg_q <= vchg_ok ? (wdata & VCHG_MASK) : '0;
            term_o <= ~vchg_ok; wr_stb <= 1'b1; wr_idx <= RI_VCHG;
          end
          CMD_IIN: begin
            iin_q <= iin_ok ? (wdata & IIN_MASK) : '0;
            term_o <= ~iin_ok; wr_stb <= 1'b1; wr_idx <= RI_IIN;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cmd)
      CMD_OPT:  rd_word = opt_q;
      CMD_ICHG: rd_word = ichg_q;
      CMD_VCHG: rd_word = vchg_q;
      CMD_IIN:  rd_word = iin_q;
      CMD_MFG:  rd_word = MFG_CODE;
      CMD_DEV:  rd_word = DEV_CODE;
      default:  rd_word = NO_REG;
    endcase
  end

  // R4
  ichg_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (ichg_q == 16'd0) || (((ichg_q & ICHG_MASK) >> ICHG_LSB) >= 16'(ICHG_MIN)));
  // R5
  vchg_window_chk: assert property (@(posedge clk) disable iff (rst)
    (vchg_q == 16'd0) || (((vchg_q >> VCHG_LSB) >= 16'(VCHG_MIN)) &&
                          ((vchg_q >> VCHG_LSB) <= 16'(VCHG_MAX))));
  // R6
  iin_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (iin_q & ~IIN_MASK) == 16'd0);
  // R10
  term_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(term_o) |-> $past(wr_en));
endmodule

// File: rtl/chg_smbus_regs.sv
module chg_smbus_regs #(
  parameter logic [6:0] ADDR7       = 7'h09,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [15:0] opt_q,
  output logic [15:0] ichg_q,
  output logic [15:0] vchg_q,
  output logic [15:0] iin_q,
  output logic        wr_stb,
  output logic [1:0]  wr_idx,
  output logic        term_o
);
  logic        sda_s, scl_rise, scl_fall, start_ev, stop_ev, wr_en;
  logic [7:0]  cmd;
  logic [15:0] wdata, rd_word;

  smb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_byte_fsm #(.ADDR7(ADDR7)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .rd_word(rd_word), .cmd_q(cmd),
    .wdata_q(wdata), .wr_en(wr_en), .sda_oe(sda_oe)
  );

  chg_reg_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(cmd), .wdata(wdata),
    .opt_q(opt_q), .ichg_q(ichg_q), .vchg_q(vchg_q), .iin_q(iin_q),
    .rd_word(rd_word), .wr_stb(wr_stb), .wr_idx(wr_idx), .term_o(term_o)
  );

  // R9
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
endmodule

// File: tb/chg_smbus_regs_bench.sv
module chg_smbus_regs_bench;
  localparam int H = 16;
  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic scl = 1'b1, m_low = 1'b0;
  logic sda_oe, wr_stb, term_o;
  logic [1:0] wr_idx;
  logic [15:0] opt_q, ichg_q, vchg_q, iin_q;
  wire sda_line = ~(m_low | sda_oe);

  chg_smbus_regs u_chg_smbus_regs (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .opt_q(opt_q), .ichg_q(ichg_q), .vchg_q(vchg_q), .iin_q(iin_q),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .term_o(term_o)
  );

  int checks = 0, fails = 0;
  int e_opt, e_ichg, e_vchg, e_iin, e_term;
  bit cmp_on = 0;
  int stb_cnt = 0, last_idx = -1;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && wr_stb) begin stb_cnt++; last_idx = int'(wr_idx); end
    if (!rst && cmp_on) begin
      chk("R7 opt", int'(opt_q), e_opt);
      chk("R4 ichg", int'(ichg_q), e_ichg);
      chk("R5 vchg", int'(vchg_q), e_vchg);
      chk("R6 iin", int'(iin_q), e_iin);
      chk("R10 term", int'(term_o), e_term);
    end
  end

  task automatic bus_start();
    m_low = 0; scl = 1; tick(H); m_low = 1; tick(H); scl = 0; tick(4);
  endtask
  task automatic bus_rstart();
    m_low = 0; tick(H); scl = 1; tick(H); m_low = 1; tick(H); scl = 0; tick(4);
  endtask
  task automatic bus_stop();
    m_low = 1; tick(H); scl = 1; tick(H); m_low = 0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ak);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(H); scl = 1; tick(H); scl = 0; tick(4);
    end
    m_low = 0; tick(H); scl = 1; tick(H/2); ak = ~sda_line; tick(H/2); scl = 0; tick(4);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1; tick(H/2); b[i] = sda_line; tick(H/2); scl = 0; tick(4);
    end
    m_low = give_ack; tick(H); scl = 1; tick(H); scl = 0; tick(4); m_low = 0;
  endtask

  // expected strobe index of a write, -1 when ignored; updates the model
  function automatic int model_write(input logic [7:0] c, input logic [15:0] d);
    int f;
    case (c)
      8'h12: begin e_opt = int'(d); return 0; end
      8'h14: begin
        f = int'((d >> 6) & 16'h7F);
        if (f >= 2) begin e_ichg = int'(d & 16'h1FC0); e_term = 0; end
        else begin e_ichg = 0; e_term = 1; end
        return 1;
      end
      8'h15: begin
        f = int'((d >> 4) & 16'h7FF);
        if (f >= 64 && f <= 1200) begin e_vchg = int'(d & 16'h7FF0); e_term = 0; end
        else begin e_vchg = 0; e_term = 1; end
        return 2;
      end
      8'h3F: begin
        f = int'((d >> 7) & 16'h3F);
        if (f >= 1) begin e_iin = int'(d & 16'h1F80); e_term = 0; end
        else begin e_iin = 0; e_term = 1; end
        return 3;
      end
      default: return -1;
    endcase
  endfunction

  task automatic do_write(input string rq, input logic [7:0] a8, input logic [7:0] c,
                          input logic [15:0] d);
    bit a0, a1, a2, a3;
    int pre, idx;
    cmp_on = 0;
    pre = stb_cnt;
    bus_start(); send_byte(a8, a0); send_byte(c, a1);
    send_byte(d[7:0], a2); send_byte(d[15:8], a3); bus_stop();
    if (a8 == 8'h12) begin
      chk({rq, " ack"}, int'(a0 & a1 & a2 & a3), 1);
      idx = model_write(c, d);
    end else begin
      chk("R1 foreign address nack", int'(a0), 0);
      idx = -1;
    end
    tick(4);
    chk("R11 released after stop", int'(sda_oe), 0);
    if (idx >= 0) begin
      chk({rq, " R9 strobe count"}, stb_cnt - pre, 1);
      chk({rq, " R9 strobe index"}, last_idx, idx);
    end else chk({rq, " R9 no strobe"}, stb_cnt - pre, 0);
    cmp_on = 1;
    tick(4);
  endtask

  task automatic do_read(input string rq, input logic [7:0] c, input int exp,
                         input bit early_nack);
    bit a0, a1, a2;
    logic [7:0] lo, hi;
    cmp_on = 0;
    bus_start(); send_byte(8'h12, a0); send_byte(c, a1);
    bus_rstart(); send_byte(8'h13, a2);
    chk({rq, " ack"}, int'(a0 & a1 & a2), 1);
    if (early_nack) begin
      recv_byte(1'b0, lo);
      chk({rq, " R2 low byte"}, int'(lo), exp & 8'hFF);
      m_low = 0; tick(H); scl = 1; tick(H/2);
      chk("R2 nothing driven after nack", int'(sda_line), 1);
      tick(H/2); scl = 0; tick(4);
    end else begin
      recv_byte(1'b1, lo); recv_byte(1'b0, hi);
      chk(rq, int'({hi, lo}), exp);
    end
    bus_stop();
    cmp_on = 1;
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    e_opt = 16'h7904; e_ichg = 0; e_vchg = 0; e_iin = 16'h1000; e_term = 0;
    tick(10); rst = 0; tick(6);
    chk("R11 reset release", int'(sda_oe), 0);
    cmp_on = 1; tick(4);

    do_read("R3 options por", 8'h12, 16'h7904, 0);
    do_read("R3 ichg por", 8'h14, 16'h0000, 0);
    do_read("R3 vchg por", 8'h15, 16'h0000, 0);
    do_read("R3 iin por", 8'h3F, 16'h1000, 0);
    do_read("R8 maker id", 8'hFE, 16'h0040, 0);
    do_read("R8 device id", 8'hFF, 16'h000A, 0);
    do_read("R8 unknown read", 8'h20, 16'hFFFF, 0);

    do_write("R1 wrong address", 8'h16, 8'h14, 16'h0FC0);
    do_write("R7 options", 8'h12, 8'h12, 16'h1234);
    do_read("R7 options readback", 8'h12, 16'h1234, 0);

    do_write("R4 ichg field1", 8'h12, 8'h14, 16'h0040);
    do_write("R10 options keep term", 8'h12, 8'h12, 16'hA5C3);
    do_write("R4 ichg field2", 8'h12, 8'h14, 16'h0080);
    do_write("R4 ichg mask", 8'h12, 8'h14, 16'hFFFF);
    do_read("R4 ichg readback", 8'h14, 16'h1FC0, 0);

    do_write("R5 vchg 63", 8'h12, 8'h15, 16'h03F0);
    do_write("R5 vchg 64", 8'h12, 8'h15, 16'h0400);
    do_write("R5 vchg 1201", 8'h12, 8'h15, 16'h4B10);
    do_write("R5 vchg 1200 masked", 8'h12, 8'h15, 16'hCB0F);
    do_read("R5 vchg readback", 8'h15, 16'h4B00, 0);

    do_write("R6 iin zero", 8'h12, 8'h3F, 16'h007F);
    do_write("R6 iin max", 8'h12, 8'h3F, 16'hFFFF);
    do_read("R6 iin readback", 8'h3F, 16'h1F80, 0);

    do_write("R8 write id ignored", 8'h12, 8'hFE, 16'h1111);
    do_write("R8 write unknown ignored", 8'h12, 8'h40, 16'h2222);
    do_read("R8 id after write", 8'hFE, 16'h0040, 0);
    do_read("R2 early nack", 8'h12, 16'hA5C3, 1);
    do_read("R2 read after nack", 8'h14, 16'h1FC0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule